// File: doc/BRIEF.md
# Reference Doubler and R Divider

This block turns a slow reference waveform into the strobe that times the phase/frequency detector. A fast system clock samples the reference through a synchronizer, and an edge detector finds the transitions. A doubler option picks which transitions count as active events. With the option off, only falling transitions count. With it on, rising and falling transitions both count, so the event rate doubles.

A programmable divider counts the active events. It emits a one-cycle strobe each time the count reaches its limit. The limit is a 4-bit value that gives ratios 1 to 15, and a value of zero is read as one. The divider takes a new ratio or doubler setting only when a division period completes, so a period is never cut short.

Two controls hold the divider at its load state for as long as either is asserted: a counter-reset input and a power-down input. While held, the divider loads the settings present on its inputs.

Top module: `pfd_ref_gen`

## Requirements
- R1: During and directly after a synchronous reset (`rst_n` low), `ref_strobe` is 0 and the divider count is zero. The first strobe after reset therefore needs a full period of active events.
- R2: When `dbl_en` was 0 at the last load, only falling transitions of `ref_in` (1 to 0) are active. Rising transitions never cause a strobe.
- R3: When `dbl_en` was 1 at the last load, both rising and falling transitions of `ref_in` are active.
- R4: With a loaded ratio N from 1 to 15, exactly one strobe is produced per N active events. The strobe comes on the N-th event counted from the last load.
- R5: An `r_val` of 0 gives a ratio of 1, so every active event produces a strobe.
- R6: `ref_strobe` is high for exactly one clock cycle per terminal count.
- R7: New `r_val` and `dbl_en` values are loaded only at a terminal count, or while the divider is held. A change made mid-period does not alter the period in progress.
- R8: While `cnt_rst` is 1, the count stays at zero, no strobe is produced, transitions of `ref_in` are ignored, and the current settings are loaded.
- R9: While `pwr_dn` is 1, the divider is held in exactly the same load state as under `cnt_rst`.
- R10: Timing of a strobe. Let edge k be the first clock edge that samples the transition completing a period. `ref_strobe` rises after edge k+2: two synchronizer stages, then the registered counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than the reference |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_in | input | 1 | Reference waveform, asynchronous to clk |
| dbl_en | input | 1 | Doubler option: 1 makes both transitions active |
| r_val | input | 4 | Divide ratio; 0 is read as 1 |
| cnt_rst | input | 1 | Holds the divider at its load state while 1 |
| pwr_dn | input | 1 | Power-down; holds the divider at its load state while 1 |
| ref_strobe | output | 1 | One-cycle reference strobe per terminal count |

## Verification
The assertions assume that `ref_in` stays at each level for at least two clock cycles. Under that assumption two active events can never reach the counter on adjacent cycles, so the strobe is always a single-cycle pulse. The stimulus keeps to this: it holds every reference level for four cycles. It changes `r_val`, `dbl_en` and the hold controls only in those quiet gaps, never within the three cycles after a transition, so each setting is stable when the counter reads it. Hold periods last at least four cycles past the last transition, so a transition still in the synchronizer is absorbed before release.

// File: rtl/pfd_ref_pkg.sv
package pfd_ref_pkg;

    localparam int unsigned RDIV_W_DEF = 4;
    localparam int unsigned SYNC_STAGES_DEF = 2;

    typedef struct packed {
        logic rise;
        logic fall;
    } ref_edges_t;

endpackage

// File: rtl/pfd_ref_sync.sv
module pfd_ref_sync
    import pfd_ref_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_STAGES_DEF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_in,
    output ref_edges_t edges
);

    localparam int unsigned CHAIN_W = STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;
    logic     lvl, prev;

    always_comb begin
        st_d       = st_q;
        st_d.chain = {st_q.chain[CHAIN_W-2:0], ref_in};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl        = st_q.chain[STAGES-1];
    assign prev       = st_q.chain[STAGES];
    assign edges.rise = lvl & ~prev;
    assign edges.fall = ~lvl & prev;

    // a transition seen on the synchronized level appears exactly once
    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        edges.rise |=> !edges.rise) else $error("edge repeated"); // R10

endmodule

// File: rtl/pfd_ref_edge_sel.sv
module pfd_ref_edge_sel
    import pfd_ref_pkg::*;
(
    input  ref_edges_t edges,
    input  logic       dbl_eff,
    output logic       active_evt
);

    always_comb begin
        active_evt = edges.fall;
        if (dbl_eff) active_evt = edges.fall | edges.rise;
    end

endmodule

// File: rtl/pfd_ref_rcount.sv
module pfd_ref_rcount #(
    parameter int unsigned R_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           hold,
    input  logic           active_evt,
    input  logic [R_W-1:0] r_val,
    input  logic           dbl_req,
    output logic           dbl_eff,
    output logic           strobe
);

    typedef struct packed {
        logic [R_W-1:0] cnt;
        logic [R_W-1:0] lim;
        logic           dbl;
        logic           stb;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    terminal;

    function automatic logic [R_W-1:0] ratio_of(input logic [R_W-1:0] r);
        return (r == '0) ? R_W'(1) : r;
    endfunction

    assign terminal = (st_q.cnt == st_q.lim - R_W'(1));

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        if (hold) begin
            st_d.cnt = '0;
            st_d.lim = ratio_of(r_val);
            st_d.dbl = dbl_req;
        end else if (active_evt) begin
            if (terminal) begin
                st_d.stb = 1'b1;
                st_d.cnt = '0;
                st_d.lim = ratio_of(r_val);
                st_d.dbl = dbl_req;
            end else begin
                st_d.cnt = st_q.cnt + R_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cnt <= '0;
            st_q.lim <= ratio_of(r_val);
            st_q.dbl <= dbl_req;
            st_q.stb <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dbl_eff = st_q.dbl;
    assign strobe  = st_q.stb;

    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !strobe) else $error("strobe wider than one cycle"); // R6
    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (!strobe && st_q.cnt == '0)) else $error("divider active while held"); // R8
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < st_q.lim) else $error("count past limit"); // R4
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !active_evt |=> !strobe) else $error("strobe without event"); // R4
    AST_LIM_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.lim != '0) else $error("zero ratio loaded"); // R5
    AST_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !(active_evt && terminal)) |=> ($stable(st_q.lim) && $stable(st_q.dbl)))
        else $error("settings changed mid-period"); // R7
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (!strobe && st_q.cnt == '0)) else $error("reset state wrong"); // R1

endmodule

// File: rtl/pfd_ref_gen.sv
module pfd_ref_gen
    import pfd_ref_pkg::*;
#(
    parameter int unsigned R_W         = RDIV_W_DEF,
    parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ref_in,
    input  logic           dbl_en,
    input  logic [R_W-1:0] r_val,
    input  logic           cnt_rst,
    input  logic           pwr_dn,
    output logic           ref_strobe
);

    ref_edges_t edges;
    logic       dbl_eff;
    logic       active_evt;
    logic       hold;

    assign hold = cnt_rst | pwr_dn;

    pfd_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .ref_in(ref_in),
        .edges (edges)
    );

    pfd_ref_edge_sel u_sel (
        .edges     (edges),
        .dbl_eff   (dbl_eff),
        .active_evt(active_evt)
    );

    pfd_ref_rcount #(.R_W(R_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .active_evt(active_evt),
        .r_val     (r_val),
        .dbl_req   (dbl_en),
        .dbl_eff   (dbl_eff),
        .strobe    (ref_strobe)
    );

    AST_RISE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (edges.rise && !dbl_eff) |=> !ref_strobe) else $error("rising edge counted"); // R2
    AST_PWRDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> !ref_strobe) else $error("strobe in power-down"); // R9
    AST_DOUBLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (edges.rise && dbl_eff && !hold && (r_val == '0) && (u_cnt.st_q.lim == R_W'(1)))
        |=> ref_strobe) else $error("rising edge missed in doubler mode"); // R3

endmodule

// File: tb/pfd_ref_gen_test.sv
module pfd_ref_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_in = 1'b0;
    logic       dbl_en = 1'b0;
    logic [3:0] r_val = 4'd1;
    logic       cnt_rst = 1'b0;
    logic       pwr_dn = 1'b0;
    logic       ref_strobe;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    int    exp_cyc[$];
    string exp_tag[$];

    int m_cnt = 0;
    int m_lim = 1;
    bit m_dbl = 1'b0;
    bit m_hold = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    pfd_ref_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_in    (ref_in),
        .dbl_en    (dbl_en),
        .r_val     (r_val),
        .cnt_rst   (cnt_rst),
        .pwr_dn    (pwr_dn),
        .ref_strobe(ref_strobe)
    );

    function automatic int lim_of(input logic [3:0] r);
        return (r == 4'd0) ? 1 : int'(r);
    endfunction

    task automatic model_load();
        m_cnt = 0;
        m_lim = lim_of(r_val);
        m_dbl = dbl_en;
    endtask

    // one reference transition, then a quiet gap of four cycles
    task automatic toggle(input string tag);
        bit active;
        @(posedge clk); #1;
        ref_in = ~ref_in;
        active = (ref_in == 1'b0) || m_dbl;
        if (active && !m_hold) begin
            m_cnt++;
            if (m_cnt == m_lim) begin
                exp_cyc.push_back(cyc + 3);
                exp_tag.push_back(tag);
                model_load();
            end
        end
        repeat (3) @(posedge clk);
    endtask

    task automatic settings(input logic [3:0] r, input logic d);
        @(posedge clk); #1;
        r_val = r;
        dbl_en = d;
    endtask

    task automatic held_window(input bit use_pd, input int n, input string tag);
        @(posedge clk); #1;
        if (use_pd) pwr_dn = 1'b1; else cnt_rst = 1'b1;
        m_hold = 1'b1;
        for (int i = 0; i < n; i++) toggle(tag);
        repeat (4) @(posedge clk);
        #1;
        model_load();
        m_hold = 1'b0;
        cnt_rst = 1'b0;
        pwr_dn = 1'b0;
    endtask

    // monitor: compare produced strobes against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (ref_strobe) begin
                total++;
                if (exp_cyc.size() == 0) begin
                    bad++;
                    $display("FAIL R2/R6/R8/R9 unexpected strobe: actual cycle=%0d expected none", cyc);
                end else if (exp_cyc[0] != cyc) begin
                    bad++;
                    $display("FAIL %s R10 strobe timing: actual cycle=%0d expected=%0d",
                             exp_tag[0], cyc, exp_cyc[0]);
                    void'(exp_cyc.pop_front());
                    void'(exp_tag.pop_front());
                end else begin
                    void'(exp_cyc.pop_front());
                    void'(exp_tag.pop_front());
                end
            end else if (exp_cyc.size() != 0 && exp_cyc[0] <= cyc) begin
                total++;
                bad++;
                $display("FAIL %s R4 missing strobe: actual none expected cycle=%0d",
                         exp_tag[0], exp_cyc[0]);
                void'(exp_cyc.pop_front());
                void'(exp_tag.pop_front());
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        r_val = 4'd1;
        dbl_en = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        total++;
        if (ref_strobe !== 1'b0) begin
            bad++;
            $display("FAIL R1 strobe in reset: actual=%b expected=0", ref_strobe);
        end
        @(posedge clk); #1;
        rst_n = 1'b1;
        model_load();
        @(negedge clk);
        total++;
        if (ref_strobe !== 1'b0) begin
            bad++;
            $display("FAIL R1 strobe after reset: actual=%b expected=0", ref_strobe);
        end

        // R2 and R4 at ratio 1: strobe only on falling transitions
        for (int i = 0; i < 6; i++) toggle("R2");
        // R5: ratio value 0 acts as 1
        settings(4'd0, 1'b0);
        for (int i = 0; i < 4; i++) toggle("R2");   // loads R=0 at next terminal
        for (int i = 0; i < 6; i++) toggle("R5");
        // R3 with ratio 3 in doubler mode
        settings(4'd3, 1'b1);
        for (int i = 0; i < 2; i++) toggle("R7");
        for (int i = 0; i < 12; i++) toggle("R3");
        // R4 at the top ratio of 15
        settings(4'd15, 1'b1);
        for (int i = 0; i < 33; i++) toggle("R4");
        // R7: mid-period change does not cut the period in progress
        settings(4'd4, 1'b0);
        for (int i = 0; i < 30; i++) toggle("R7");
        for (int i = 0; i < 3; i++) toggle("R7");
        settings(4'd2, 1'b1);
        for (int i = 0; i < 12; i++) toggle("R7");
        // R8: counter reset mid-count
        settings(4'd5, 1'b0);
        for (int i = 0; i < 12; i++) toggle("R8");
        settings(4'd3, 1'b0);
        held_window(1'b0, 6, "R8");
        for (int i = 0; i < 12; i++) toggle("R8");
        // R9: power-down mid-count, loads doubler mode
        settings(4'd2, 1'b1);
        for (int i = 0; i < 3; i++) toggle("R9");
        held_window(1'b1, 5, "R9");
        for (int i = 0; i < 8; i++) toggle("R9");

        repeat (10) @(posedge clk);
        @(negedge clk);
        total++;
        if (exp_cyc.size() != 0) begin
            bad++;
            $display("FAIL R4 strobes outstanding: actual=%0d expected=0", exp_cyc.size());
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule